// File: doc/BRIEF.md
# Stack Push Address Generator

This block turns one stack-push instruction word into the ordered list of stores that the push performs. It recognises two encodings. The first is a store-multiple to the stack pointer that decrements before each store and writes the pointer back. The second is a pre-indexed single-word store with write-back. For each register that the push saves, it emits a register number and a byte address, one pair per cycle, under a valid/ready handshake. When the last pair has been accepted, it gives the written-back stack pointer together with a one-cycle completion pulse.

A multi-register push is treated as one operation. The block computes the lowest address from the number of saved registers, then walks upward from there, so that the lowest-numbered register lands at the new stack pointer. A single-register store becomes a one-entry push with the same result as a one-bit store-multiple. An empty register list raises an illegal flag, and any other encoding raises an unsupported flag. In both of those cases no stores are produced and the stack pointer is returned unchanged.

Top module: `stack_push_agen`

## Requirements
- R1: A word whose bits [31:16] equal 0xE92D is a store-multiple push, and bit n of bits [15:0] set means register n is stored. Exactly one entry is emitted per set bit, and one push word is never split into separate operations.
- R2: Entries come out in ascending register number. The first address is sp_i − 4·count, where count is the number of stored registers, and each later entry is 4 bytes above the previous one.
- R3: One cycle after the last entry is accepted, done_o is high for exactly one cycle and sp_wb_o equals sp_i − 4·count. sp_wb_o then holds that value.
- R4: A word with bits [31:16] = 0xE52D and bits [11:0] = 0x004 is a single-register push of the register numbered in bits [15:12]. It yields the same entry, address and sp_wb_o as a store-multiple with only that bit set.
- R5: A store-multiple with an all-zero register list emits no entry. The cycle after start, illegal_o and done_o are high for one cycle, and sp_wb_o equals sp_i.
- R6: Any other word, including a single store whose low 12 bits are not 0x004, emits no entry. The cycle after start, unsupp_o and done_o are high for one cycle, and sp_wb_o equals sp_i.
- R7: While out_valid_o is high and out_ready_i is low, out_valid_o, out_reg_o and out_addr_o hold their values. At most one entry is accepted per cycle.
- R8: busy_o is high from the cycle after an accepted push start until done_o. A start_i pulse while busy_o is high is ignored and changes neither the entries nor sp_wb_o.
- R9: After reset, busy_o, out_valid_o, done_o, illegal_o and unsupp_o are low and sp_wb_o is zero.
- R10: For a valid non-empty push, the first entry is valid in the cycle right after the start cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; taken only while busy_o is low |
| instr_i | input | 32 | Push instruction word, sampled with start_i |
| sp_i | input | ADDR_W | Stack pointer before the push, sampled with start_i |
| busy_o | output | 1 | An accepted push is emitting entries |
| out_valid_o | output | 1 | An entry is presented |
| out_ready_i | input | 1 | Consumer accepts the presented entry |
| out_reg_o | output | 4 | Register number of the presented entry |
| out_addr_o | output | ADDR_W | Byte address of the presented entry |
| done_o | output | 1 | One-cycle completion pulse |
| sp_wb_o | output | ADDR_W | Written-back stack pointer |
| illegal_o | output | 1 | Empty register list, pulsed with done_o |
| unsupp_o | output | 1 | Unrecognised encoding, pulsed with done_o |

## Verification
The push is tried with several register lists:
- A single register shows the base equals the final pointer.
- A contiguous run of three registers checks the ascending walk.
- A sparse list with r0, r2 and r15 catches a scan that skips or reorders bits.
- A full sixteen-register list checks the widest count and address range.

The single-store encoding is run with the same register and pointer as the one-bit multiple, so that any difference between the two forms shows up. Empty lists, a pop word and a single store with a wrong offset separate the illegal path from the unsupported path. Runs with alternating ready, and a start pulse while busy, check holding behaviour and that a second start is ignored.

// File: rtl/stack_push_agen_pkg.sv
package stack_push_agen_pkg;

  localparam int REG_COUNT = 16;
  localparam int REG_IDX_W = $clog2(REG_COUNT);
  localparam int CNT_W     = $clog2(REG_COUNT + 1);
  localparam int INSTR_W   = 32;

  localparam logic [15:0] OP_MULTI_PUSH  = 16'hE92D;
  localparam logic [15:0] OP_SINGLE_PUSH = 16'hE52D;
  localparam logic [11:0] SINGLE_OFFSET  = 12'h004;

  typedef logic [REG_COUNT-1:0] reg_mask_t;

  typedef enum logic [1:0] {
    FORM_MULTI  = 2'd0,
    FORM_SINGLE = 2'd1,
    FORM_OTHER  = 2'd2
  } push_form_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } seq_state_e;

  // number of registers named in a list
  function automatic logic [CNT_W-1:0] f_mask_count(input reg_mask_t m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      c = c + CNT_W'(m[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/spag_decode.sv
module spag_decode
  import stack_push_agen_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output push_form_e         form_o,
  output reg_mask_t          mask_o
);

  logic [15:0] opcode;
  logic [11:0] offset;
  logic [3:0]  single_reg;

  assign opcode     = instr_i[31:16];
  assign offset     = instr_i[11:0];
  assign single_reg = instr_i[15:12];

  always_comb begin
    form_o = FORM_OTHER;
    mask_o = '0;
    if (opcode == OP_MULTI_PUSH) begin
      form_o = FORM_MULTI;
      mask_o = instr_i[REG_COUNT-1:0];
    end else if ((opcode == OP_SINGLE_PUSH) && (offset == SINGLE_OFFSET)) begin
      form_o = FORM_SINGLE;
      mask_o = reg_mask_t'(1) << single_reg;
    end
  end

endmodule

// File: rtl/spag_scan.sv
module spag_scan
  import stack_push_agen_pkg::*;
(
  input  reg_mask_t              mask_i,
  output logic [REG_IDX_W-1:0]   idx_o,
  output reg_mask_t              pick_o,
  output logic                   any_o,
  output logic                   last_o
);

  // below[i] is set when any bit under position i is set
  logic [REG_COUNT:0] below;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : g_chain
      assign below[g+1] = below[g] | mask_i[g];
      assign pick_o[g]  = mask_i[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (pick_o[i]) idx_o = idx_o | REG_IDX_W'(i);
    end
  end

  assign any_o  = below[REG_COUNT];
  assign last_o = any_o && ((mask_i & ~pick_o) == '0);

endmodule

// File: rtl/spag_seq.sv
module spag_seq
  import stack_push_agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  push_form_e        form_i,
  input  reg_mask_t         dec_mask_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  reg_mask_t         pick_i,
  input  logic              last_i,
  input  logic              out_ready_i,
  output reg_mask_t         mask_q_o,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_wb_o,
  output logic              illegal_o,
  output logic              unsupp_o,
  output logic              start_take_o,
  output logic              fire_o,
  output logic              last_fire_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // lowest address of the push: pointer minus one word per register
  function automatic logic [ADDR_W-1:0] f_push_base(input logic [ADDR_W-1:0] sp,
                                                   input logic [CNT_W-1:0]  cnt);
    return sp - (ADDR_W'(cnt) * STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] f_next_addr(input logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  seq_state_e        state_q;
  reg_mask_t         mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] newsp_q;
  logic [ADDR_W-1:0] spwb_q;
  logic              done_q;
  logic              ill_q;
  logic              uns_q;

  logic              empty_list;
  logic [ADDR_W-1:0] base_addr;

  assign empty_list   = (dec_mask_i == '0);
  assign base_addr    = f_push_base(sp_i, f_mask_count(dec_mask_i));
  assign start_take_o = start_i && (state_q == ST_IDLE);
  assign out_valid_o  = (state_q == ST_EMIT);
  assign fire_o       = out_valid_o && out_ready_i;
  assign last_fire_o  = fire_o && last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      newsp_q <= '0;
      spwb_q  <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      uns_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      uns_q  <= 1'b0;
      if (start_take_o) begin
        if (form_i == FORM_OTHER) begin
          done_q <= 1'b1;
          uns_q  <= 1'b1;
          spwb_q <= sp_i;
        end else if (empty_list) begin
          done_q <= 1'b1;
          ill_q  <= 1'b1;
          spwb_q <= sp_i;
        end else begin
          state_q <= ST_EMIT;
          mask_q  <= dec_mask_i;
          addr_q  <= base_addr;
          newsp_q <= base_addr;
        end
      end else if (fire_o) begin
        mask_q <= mask_q & ~pick_i;
        addr_q <= f_next_addr(addr_q);
        if (last_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          spwb_q  <= newsp_q;
        end
      end
    end
  end

  assign mask_q_o  = mask_q;
  assign addr_o    = addr_q;
  assign busy_o    = (state_q == ST_EMIT);
  assign done_o    = done_q;
  assign sp_wb_o   = spwb_q;
  assign illegal_o = ill_q;
  assign unsupp_o  = uns_q;

endmodule

// File: rtl/stack_push_agen.sv
module stack_push_agen
  import stack_push_agen_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [ADDR_W-1:0]    sp_i,
  output logic                 busy_o,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [REG_IDX_W-1:0] out_reg_o,
  output logic [ADDR_W-1:0]    out_addr_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    sp_wb_o,
  output logic                 illegal_o,
  output logic                 unsupp_o
);

  push_form_e dec_form;
  reg_mask_t  dec_mask;
  reg_mask_t  live_mask;
  reg_mask_t  pick;
  logic       live_any;
  logic       live_last;

  // named events for the checker
  logic start_take;
  logic hs_fire;
  logic hs_last;

  spag_decode u_decode (
    .instr_i (instr_i),
    .form_o  (dec_form),
    .mask_o  (dec_mask)
  );

  spag_scan u_scan (
    .mask_i (live_mask),
    .idx_o  (out_reg_o),
    .pick_o (pick),
    .any_o  (live_any),
    .last_o (live_last)
  );

  spag_seq #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .form_i       (dec_form),
    .dec_mask_i   (dec_mask),
    .sp_i         (sp_i),
    .pick_i       (pick),
    .last_i       (live_last),
    .out_ready_i  (out_ready_i),
    .mask_q_o     (live_mask),
    .out_valid_o  (out_valid_o),
    .addr_o       (out_addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .sp_wb_o      (sp_wb_o),
    .illegal_o    (illegal_o),
    .unsupp_o     (unsupp_o),
    .start_take_o (start_take),
    .fire_o       (hs_fire),
    .last_fire_o  (hs_last)
  );

endmodule

// File: rtl/stack_push_agen_chk.sv
module stack_push_agen_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDX_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDX_W-1:0]  out_reg,
  input logic [ADDR_W-1:0] out_addr,
  input logic              done,
  input logic              illegal,
  input logic              unsupp,
  input logic              live_any,
  input logic              hs_fire,
  input logic              hs_last
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_reg) && $stable(out_addr)); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fire && !hs_last |=> out_valid && (out_addr == $past(out_addr) + ADDR_W'(WORD_BYTES))); // R2

  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fire && !hs_last |=> out_reg > $past(out_reg)); // R2

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_last |=> done && !out_valid && !illegal && !unsupp); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, unsupp})); // R5

  AST_FLAG_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || unsupp) |-> done && !out_valid); // R6

  AST_VALID_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy && live_any); // R8

endmodule

bind stack_push_agen stack_push_agen_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES),
  .IDX_W      (stack_push_agen_pkg::REG_IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .out_valid (out_valid_o),
  .out_ready (out_ready_i),
  .out_reg   (out_reg_o),
  .out_addr  (out_addr_o),
  .done      (done_o),
  .illegal   (illegal_o),
  .unsupp    (unsupp_o),
  .live_any  (live_any),
  .hs_fire   (hs_fire),
  .hs_last   (hs_last)
);

// File: tb/stack_push_agen_tb.sv
`timescale 1ns/100ps
module stack_push_agen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] sp_i = '0;
  logic        busy_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [3:0]  out_reg_o;
  logic [31:0] out_addr_o;
  logic        done_o;
  logic [31:0] sp_wb_o;
  logic        illegal_o;
  logic        unsupp_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  stack_push_agen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .instr_i     (instr_i),
    .sp_i        (sp_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_reg_o   (out_reg_o),
    .out_addr_o  (out_addr_o),
    .done_o      (done_o),
    .sp_wb_o     (sp_wb_o),
    .illegal_o   (illegal_o),
    .unsupp_o    (unsupp_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      finish_run();
    end
  end

  // kind: 0 normal push, 1 empty list, 2 unsupported word
  task automatic run_push(input logic [31:0] instr, input logic [31:0] sp,
                          input logic [15:0] emask, input int kind,
                          input bit stall, input bit poke, input string tag,
                          output logic [31:0] wb);
    int cnt = 0;
    int k = 0;
    int n = 0;
    bit got_done = 0;
    bit pv = 0;
    bit pr = 0;
    logic [3:0]  preg = '0;
    logic [31:0] paddr = '0;
    logic [31:0] base;
    for (int b = 0; b < 16; b++) if (emask[b]) cnt++;
    base = sp - 32'(4 * cnt);
    wb = 'x;
    @(negedge clk);
    instr_i = instr;
    sp_i    = sp;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    instr_i = 32'hE92D_FFFF;
    sp_i    = 32'h0000_0100;
    for (int cyc = 0; cyc < 80 && !got_done; cyc++) begin
      out_ready_i = stall ? (cyc % 2 == 1) : 1'b1;
      start_i = (poke && cyc == 1);
      #1;
      if (cyc == 0) begin
        chk(out_valid_o == (kind == 0), "R10", {tag, " first entry valid"},
            32'(out_valid_o), 32'(kind == 0));
        chk(busy_o == (kind == 0), "R8", {tag, " busy after start"},
            32'(busy_o), 32'(kind == 0));
      end
      if (pv && !pr) begin
        chk(out_valid_o && out_reg_o == preg && out_addr_o == paddr, "R7",
            {tag, " hold under stall"}, out_addr_o, paddr);
      end
      if (out_valid_o && out_ready_i) begin
        while (n < 16 && !emask[n]) n++;
        chk(n < 16 && out_reg_o == 4'(n), "R2", {tag, " register order"},
            32'(out_reg_o), 32'(n));
        chk(out_addr_o == base + 32'(4 * k), "R2", {tag, " entry address"},
            out_addr_o, base + 32'(4 * k));
        k++;
        n++;
      end
      if (done_o) begin
        got_done = 1;
        wb = sp_wb_o;
        chk(k == cnt, "R1", {tag, " entry count"}, 32'(k), 32'(cnt));
        chk(sp_wb_o == ((kind == 0) ? base : sp), "R3", {tag, " written-back pointer"},
            sp_wb_o, (kind == 0) ? base : sp);
        chk(illegal_o == (kind == 1), "R5", {tag, " illegal flag"},
            32'(illegal_o), 32'(kind == 1));
        chk(unsupp_o == (kind == 2), "R6", {tag, " unsupported flag"},
            32'(unsupp_o), 32'(kind == 2));
        chk(!busy_o && !out_valid_o, "R8", {tag, " idle at done"},
            32'(busy_o | out_valid_o), 32'd0);
      end
      pv    = out_valid_o;
      pr    = out_ready_i;
      preg  = out_reg_o;
      paddr = out_addr_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    out_ready_i = 1'b0;
    chk(got_done, "R3", {tag, " done seen"}, 32'(got_done), 32'd1);
    #1;
    chk(!done_o && !out_valid_o && !illegal_o && !unsupp_o, "R3", {tag, " done is one pulse"},
        32'(done_o), 32'd0);
    chk(sp_wb_o == wb, "R3", {tag, " pointer holds"}, sp_wb_o, wb);
  endtask

  task automatic test_reset();
    #1;
    chk(!busy_o && !out_valid_o && !done_o && !illegal_o && !unsupp_o, "R9",
        "reset outputs low", {27'd0, busy_o, out_valid_o, done_o, illegal_o, unsupp_o}, 32'd0);
    chk(sp_wb_o == 32'd0, "R9", "reset pointer", sp_wb_o, 32'd0);
  endtask

  task automatic test_single_forms();
    logic [31:0] wb_multi;
    logic [31:0] wb_store;
    run_push(32'hE92D_0800, 32'h0000_1000, 16'h0800, 0, 0, 0, "R1 one-bit multiple", wb_multi);
    run_push(32'hE52D_B004, 32'h0000_1000, 16'h0800, 0, 0, 0, "R4 single store", wb_store);
    chk(wb_store == wb_multi, "R4", "single store equals one-bit multiple", wb_store, wb_multi);
    run_push(32'hE52D_3004, 32'h0000_0010, 16'h0008, 0, 1, 0, "R4 single store r3", wb_store);
  endtask

  task automatic test_lists();
    logic [31:0] wb;
    run_push(32'hE92D_1C00, 32'h0000_2020, 16'h1C00, 0, 1, 0, "R1 contiguous stalled", wb);
    run_push(32'hE92D_8005, 32'h0000_3000, 16'h8005, 0, 1, 0, "R2 sparse", wb);
    run_push(32'hE92D_FFFF, 32'h0000_4000, 16'hFFFF, 0, 0, 0, "R1 full list", wb);
  endtask

  task automatic test_rejects();
    logic [31:0] wb;
    run_push(32'hE92D_0000, 32'h0000_5000, 16'h0000, 1, 0, 0, "R5 empty list", wb);
    run_push(32'hE8BD_0003, 32'h0000_6000, 16'h0000, 2, 0, 0, "R6 pop word", wb);
    run_push(32'hE52D_B008, 32'h0000_7000, 16'h0000, 2, 0, 0, "R6 wrong offset", wb);
  endtask

  task automatic test_busy_start();
    logic [31:0] wb;
    run_push(32'hE92D_1C00, 32'h0000_8000, 16'h1C00, 0, 1, 1, "R8 start while busy", wb);
    chk(wb == 32'h0000_7FF4, "R8", "pointer unaffected by ignored start", wb, 32'h0000_7FF4);
  endtask

  initial begin
    #1;
    test_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_single_forms();
    test_lists();
    test_rejects();
    test_busy_start();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule